// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Collision Flag

This block moves one byte at a time over a four-wire synchronous serial link, either as the clocking side (master) or as the clocked side (slave). A host sets the role, clock idle level, clock phase, enable and per-pin direction enables through a single control word. It then writes the byte to send into the data port and reads the received byte back from the same port. Two sticky status flags report a finished byte and a rejected write.

As master, the block derives its serial clock from the system clock with a fixed divider. A host write starts a transfer of eight clock cycles, most significant bit first. As slave, the block synchronizes the incoming clock, select and data lines into the system clock domain and follows the external master. With the first clock phase the select line frames each byte and must be released between bytes. With the second phase the select may stay low and bytes are counted from clock edges. A host write that arrives while a byte is in flight is dropped and raises the collision flag.

Top module: `spi_port`

## Requirements
- R1: After reset both flags are 0, the received-data port reads 0 and every output enable (`sck_oe`, `mosi_oe`, `miso_oe`) is 0.
- R2: Control word bits are: bit 0 clock phase, bit 1 clock idle level, bit 2 master role, bit 3 enable, bit 4 clock pin direction, bit 5 master-out pin direction, bit 6 slave-out pin direction. In master role a data write that is sampled on clock edge 0 produces serial clock edges on system edges 2, 4, … 32. The transfer-complete flag is set after edge 32.
- R3: `sck_o` rests at the idle level from bit 1 between transfers and during the first cycle of a transfer. It toggles away from that level on the leading edge of each of the eight serial cycles.
- R4: With phase 0 the master puts the most significant bit on `mosi_o` before the first leading edge, samples `miso_i` on leading edges and changes `mosi_o` on trailing edges. After the byte, the data port holds the received byte.
- R5: With phase 1 the master drives each bit on `mosi_o` at the leading edge and samples `miso_i` on the trailing edge. The order is most significant bit first.
- R6: A master data write while a transfer runs sets the collision flag in the next cycle and leaves the running transfer unchanged.
- R7: As slave with phase 0, the first bit is on `miso_o` once select is low, and each incoming byte on `mosi_i` appears in the data port together with the transfer-complete flag.
- R8: As slave with phase 0, a data write while select is low is rejected. The shift register keeps its old content and the collision flag is set.
- R9: As slave with phase 0, once a byte completes, further clock cycles are ignored until select has gone high and low again.
- R10: As slave with phase 1, select may stay low across back-to-back bytes. A data write between bytes, with no clock cycle yet counted, is accepted.
- R11: As slave, select going high in the middle of a byte aborts it. No completion flag is raised and the next byte starts from bit 7.
- R12: Both flags stay set until a status read (`stat_re`) is followed by a data-port access (`data_re` or `data_we`). A data access with no status read before it clears nothing.
- R13: `sck_oe` and `mosi_oe` are high only in master role with their direction bit set. `miso_oe` is high only in slave role with its direction bit set. All three are low when the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word (see R2) |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | DW | Byte to transmit |
| data_re | input | 1 | Data port read access |
| data_rdata | output | DW | Last received byte |
| stat_re | input | 1 | Status read access |
| flag_done | output | 1 | Transfer-complete flag |
| flag_wcol | output | 1 | Write-collision flag |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master-out data |
| mosi_oe | output | 1 | Master-out output enable |
| mosi_i | input | 1 | Master-out data in (slave) |
| miso_o | output | 1 | Slave-out data |
| miso_oe | output | 1 | Slave-out output enable |
| miso_i | input | 1 | Slave-out data in (master) |
| ss_n_i | input | 1 | Active-low slave select in |

## Verification
The bench builds the block with its defaults: an 8-bit byte, a divide-by-4 clock and a two-stage synchronizer. With these values a whole master transfer is 33 system cycles, short enough to compare the serial clock and both flags against the model on every cycle of every transfer. The slave tests drive an external clock eight system cycles per half period, so the two-stage synchronizer latency always fits inside a half period. This leaves the framing rules, the collision cases and the abort path as the boundaries under test.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW   = 8,
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [6:0]    ctl_wdata,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  input  logic          data_re,
  output logic [DW-1:0] data_rdata,
  input  logic          stat_re,
  output logic          flag_done,
  output logic          flag_wcol,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i,
  input  logic          ss_n_i
);
  localparam int HALF = DIV / 2;
  localparam int DCW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDG  = 2 * DW;
  localparam int HW   = $clog2(EDG);
  localparam int BW   = $clog2(DW);

  logic [6:0] ctl;
  logic cpha, cpol, mstr, en;
  assign cpha = ctl[0];
  assign cpol = ctl[1];
  assign mstr = ctl[2];
  assign en   = ctl[3];

  logic [SYNC-1:0] sck_sy, ss_sy, mosi_sy;
  logic sck_d, act_s, act_d, ss_lo, mosi_s;
  assign act_s  = sck_sy[SYNC-1] ^ cpol;
  assign act_d  = sck_d ^ cpol;
  assign ss_lo  = ~ss_sy[SYNC-1];
  assign mosi_s = mosi_sy[SYNC-1];

  logic busy, m_act;
  logic [DCW-1:0] divc;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bcnt;
  logic spent;
  logic [DW-1:0] shreg, rxbuf;
  logic rxbit, oq, arm;

  logic m_tick, m_lead, m_trail, m_last;
  logic s_go, s_lead, s_trail, s_last;
  logic lead, trail, last, sin, coll, wr_ok, wr_col, clr;
  logic [DW-1:0] shifted;

  assign m_tick  = busy && (divc == DCW'(HALF - 1));
  assign m_lead  = m_tick && !hcnt[0];
  assign m_trail = m_tick && hcnt[0];
  assign m_last  = m_tick && (hcnt == HW'(EDG - 1));

  assign s_go    = en && !mstr && ss_lo && !spent;
  assign s_lead  = s_go && act_s && !act_d;
  assign s_trail = s_go && !act_s && act_d;
  assign s_last  = s_trail && (bcnt == BW'(DW - 1));

  assign lead    = mstr ? m_lead  : s_lead;
  assign trail   = mstr ? m_trail : s_trail;
  assign last    = mstr ? m_last  : s_last;
  assign sin     = mstr ? miso_i  : mosi_s;
  assign shifted = {shreg[DW-2:0], cpha ? sin : rxbit};

  assign coll   = mstr ? busy : (cpha ? (bcnt != '0) : ss_lo);
  assign wr_ok  = data_we && en && !coll;
  assign wr_col = data_we && en && coll;
  assign clr    = arm && (data_we || data_re);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      sck_sy  <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      sck_sy  <= {sck_sy[SYNC-2:0], sck_i};
      ss_sy   <= {ss_sy[SYNC-2:0], ss_n_i};
      mosi_sy <= {mosi_sy[SYNC-2:0], mosi_i};
      sck_d   <= sck_sy[SYNC-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      m_act <= 1'b0;
      divc  <= '0;
      hcnt  <= '0;
    end else if (wr_ok && mstr) begin
      busy  <= 1'b1;
      m_act <= 1'b0;
      divc  <= '0;
      hcnt  <= '0;
    end else if (m_tick) begin
      divc  <= '0;
      m_act <= ~m_act;
      hcnt  <= hcnt + 1'b1;
      if (m_last) busy <= 1'b0;
    end else if (busy) begin
      divc <= divc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt  <= '0;
      spent <= 1'b0;
    end else begin
      if (mstr || !ss_lo) bcnt <= '0;
      else if (s_trail) bcnt <= bcnt + 1'b1;
      if (!ss_lo) spent <= 1'b0;
      else if (s_last && !cpha) spent <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      rxbuf <= '0;
      rxbit <= 1'b0;
      oq    <= 1'b0;
    end else begin
      if (lead) begin
        rxbit <= sin;
        oq    <= shreg[DW-1];
      end
      if (wr_ok) shreg <= data_wdata;
      else if (trail) shreg <= shifted;
      if (last) rxbuf <= shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_done <= 1'b0;
      flag_wcol <= 1'b0;
      arm       <= 1'b0;
    end else begin
      flag_done <= (flag_done && !clr) || last;
      flag_wcol <= (flag_wcol && !clr) || wr_col;
      if (stat_re) arm <= 1'b1;
      else if (data_we || data_re) arm <= 1'b0;
    end
  end

  assign data_rdata = rxbuf;
  assign sck_o      = cpol ^ (mstr & m_act);
  assign mosi_o     = cpha ? oq : shreg[DW-1];
  assign miso_o     = mosi_o;
  assign sck_oe     = en & mstr & ctl[4];
  assign mosi_oe    = en & mstr & ctl[5];
  assign miso_oe    = en & ~mstr & ctl[6];

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flag_done); // R2
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr && !busy) |-> (sck_o == cpol)); // R3
  AST_WCOL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_col && !trail) |=> $stable(shreg)); // R8
  AST_SPENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spent && ss_lo && !mstr && !flag_done && !ctl_we) |=> !flag_done); // R9
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mstr && !ss_lo && !flag_done && !ctl_we) |=> !flag_done); // R11
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, data_we = 0, data_re = 0, stat_re = 0;
  logic [6:0] ctl_wdata = '0;
  logic [7:0] data_wdata = '0, data_rdata;
  logic flag_done, flag_wcol;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re),
    .data_rdata(data_rdata), .stat_re(stat_re), .flag_done(flag_done),
    .flag_wcol(flag_wcol), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(input logic [6:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk); data_we = 1; data_wdata = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); stat_re = 1;
    @(negedge clk); stat_re = 0; data_re = 1;
    @(negedge clk); data_re = 0;
  endtask

  // Reference model of the master sequence: expected clock level, flags and
  // peer behaviour are derived from the cycle index n after the write edge.
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] peer,
                             input bit cpha, input bit cpol, input bit extra);
    logic [7:0] got = '0;
    @(negedge clk); data_we = 1; data_wdata = tx;
    miso_i = cpha ? 1'b0 : peer[7];
    for (int n = 0; n <= 34; n++) begin
      @(negedge clk);
      if (n == 0) data_we = 0;
      if (n == 11) data_we = 0;
      check("R2/R3 sck level", sck_o, (n <= 32) ? (cpol ^ ((n / 2) % 2)) : cpol);
      check("R2 done timing", flag_done, n >= 32);
      check("R6 wcol timing", flag_wcol, extra && n >= 11);
      if (!cpha) begin
        if (n % 4 == 2 && n <= 30) got[7 - (n - 2) / 4] = mosi_o;
        if (n % 4 == 0 && n >= 4 && n <= 28) miso_i = peer[7 - n / 4];
      end else begin
        if (n % 4 == 2 && n <= 30) miso_i = peer[7 - (n - 2) / 4];
        if (n % 4 == 0 && n >= 4 && n <= 32) got[7 - (n - 4) / 4] = mosi_o;
      end
      if (extra && n == 10) begin data_we = 1; data_wdata = ~tx; end
    end
    check(cpha ? "R5 mosi byte" : "R4 mosi byte", got, tx);
    check(cpha ? "R5 rx byte" : "R4 rx byte", data_rdata, peer);
  endtask

  task automatic slave_bits(input logic [7:0] mtx, input bit cpha, input bit cpol,
                            input int nbits, output logic [7:0] got);
    got = '0;
    for (int b = 0; b < nbits; b++) begin
      if (!cpha) begin
        mosi_i = mtx[7 - b]; wait_n(4);
        sck_i = ~cpol; wait_n(8);
        got[7 - b] = miso_o;
        sck_i = cpol; wait_n(4);
      end else begin
        sck_i = ~cpol; mosi_i = mtx[7 - b]; wait_n(8);
        got[7 - b] = miso_o;
        sck_i = cpol; wait_n(8);
      end
    end
    wait_n(6);
  endtask

  task automatic ss_set(input logic v);
    ss_n_i = v; wait_n(6);
  endtask

  initial begin
    logic [7:0] g;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    check("R1 done", flag_done, 0);
    check("R1 wcol", flag_wcol, 0);
    check("R1 rdata", data_rdata, 0);
    check("R1 oe", {sck_oe, mosi_oe, miso_oe}, 0);

    // R13 direction gating
    set_ctl(7'h0C);
    check("R13 no dir", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    set_ctl(7'h7C);
    check("R13 master dir", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    set_ctl(7'h74);
    check("R13 disabled", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    set_ctl(7'h48);
    check("R13 slave dir", {sck_oe, mosi_oe, miso_oe}, 3'b001);

    // Master transfers: R2..R6
    set_ctl(7'h7C);
    master_xfer(8'hB2, 8'h4D, 0, 0, 0);
    clear_flags();
    set_ctl(7'h7E);
    master_xfer(8'h69, 8'hF0, 0, 1, 0);
    clear_flags();
    set_ctl(7'h7D);
    master_xfer(8'h0F, 8'h96, 1, 0, 0);
    clear_flags();
    set_ctl(7'h7F);
    wait_n(2);
    check("R3 idle high", sck_o, 1);
    master_xfer(8'h1E, 8'hE1, 1, 1, 1);
    // R12: data access without status read keeps flags
    @(negedge clk); data_re = 1; @(negedge clk); data_re = 0;
    check("R12 sticky done", flag_done, 1);
    check("R12 sticky wcol", flag_wcol, 1);
    clear_flags();
    check("R12 cleared done", flag_done, 0);
    check("R12 cleared wcol", flag_wcol, 0);

    // Slave phase 0: R7
    set_ctl(7'h48);
    sck_i = 0;
    host_write(8'hA5);
    ss_set(0);
    check("R7 first bit on miso", miso_o, 1);
    slave_bits(8'h3C, 0, 0, 8, g);
    check("R7 miso byte", g, 8'hA5);
    check("R7 rx byte", data_rdata, 8'h3C);
    check("R7 done", flag_done, 1);
    ss_set(1);
    clear_flags();

    // R8 collision while select low
    host_write(8'h5A);
    ss_set(0);
    host_write(8'h11);
    check("R8 wcol", flag_wcol, 1);
    slave_bits(8'hC7, 0, 0, 8, g);
    check("R8 old data sent", g, 8'h5A);
    check("R8 rx byte", data_rdata, 8'hC7);
    check("R12 wcol sticky", flag_wcol, 1);
    clear_flags();

    // R9 extra clocks with select still low are ignored
    slave_bits(8'h33, 0, 0, 8, g);
    check("R9 no done", flag_done, 0);
    check("R9 rx kept", data_rdata, 8'hC7);
    ss_set(1);

    // R11 abort mid-byte
    ss_set(0);
    slave_bits(8'hFF, 0, 0, 3, g);
    ss_set(1);
    check("R11 no done", flag_done, 0);
    ss_set(0);
    slave_bits(8'h96, 0, 0, 8, g);
    check("R11 next byte", data_rdata, 8'h96);
    check("R11 done after full", flag_done, 1);
    ss_set(1);
    clear_flags();

    // R10 phase 1 back-to-back, idle high
    sck_i = 1;
    set_ctl(7'h4B);
    host_write(8'hC3);
    ss_set(0);
    slave_bits(8'h81, 1, 1, 8, g);
    check("R10 miso byte 1", g, 8'hC3);
    check("R10 rx byte 1", data_rdata, 8'h81);
    check("R10 done 1", flag_done, 1);
    clear_flags();
    host_write(8'h7E);
    check("R10 write accepted", flag_wcol, 0);
    slave_bits(8'h42, 1, 1, 8, g);
    check("R10 miso byte 2", g, 8'h7E);
    check("R10 rx byte 2", data_rdata, 8'h42);
    check("R10 done 2", flag_done, 1);
    ss_set(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule